// File: doc/BRIEF.md
# DRAM row boundary decoder

This block maps a 4 KiB physical page number onto the chip-select row of a DRAM array that holds it. Software programs one cumulative boundary value per row, an attribute word that carries each row's device width, and a controller mode word that sets the boundary unit, the channel count and whether data integrity checking is on. A lookup request presents a page number. One cycle later the block returns whether the page is installed, which row holds it, that row's device width, and the error-correction scheme that applies to the row.

Boundaries are cumulative. Row i starts where row i-1 ends, so the last boundary gives the total installed memory. A row whose boundary does not rise above its predecessor is empty and is never selected. A combinational debug port reports the first page, last page, size, population and correction scheme of any row.

Top module: `drbd_decoder`

## Requirements
- R1: Register writes are decoded by `wr_addr`. Addresses 0 to 7 load the boundary of that row from `wr_data[7:0]`. Address 8 loads the attribute word. Address 9 loads the mode word. Writes to any other address change nothing.
- R2: A boundary b is converted to a cumulative page count b << (13 + g), where g is mode bit 18. This gives 32 MiB units when g is 0 and 64 MiB units when g is 1.
- R3: A populated row i covers pages from the cumulative count of row i-1 (0 for row 0) up to its own cumulative count minus one. A lookup inside that range returns hit 1 and row i.
- R4: A row whose cumulative count is not above that of the previous row is unpopulated and never produces a hit.
- R5: A page at or beyond the top of installed memory returns hit 0, row 0, x4 flag 0 and correction code 0.
- R6: Bit 4*i+3 of the attribute word is the device width of row i (0 = x8, 1 = x4). A hit reports it on `lkp_x4`.
- R7: When mode bits 21:20 are both zero, every row reports correction code 0 (none).
- R8: When mode bits 21:20 are non-zero, a populated row reports code 2 (4-bit symbol correction) if mode bit 22 is 1 (dual channel) and the row is x4. Otherwise it reports code 1 (single-error correct, double-error detect).
- R9: `lkp_valid` is high for exactly the cycle after a cycle with `lkp_req` high. The result fields then reflect the page and registers sampled at the request edge, and hold their values until the next request.
- R10: The debug port reports, for row `dbg_row`, its population flag, first page, last page, size in pages and correction code. An unpopulated row shows size 0, first 0, last 0 and code 0.
- R11: After reset all registers are zero, so every row is unpopulated and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| lkp_req | input | 1 | Lookup request strobe |
| lkp_page | input | 22 | Page number to look up |
| lkp_valid | output | 1 | Lookup result valid pulse |
| lkp_hit | output | 1 | Page lies in a populated row |
| lkp_row | output | 3 | Row holding the page |
| lkp_x4 | output | 1 | Row built from x4 devices |
| lkp_ecc | output | 2 | Correction code: 0 none, 1 SECDED, 2 symbol |
| dbg_row | input | 3 | Row selected for debug view |
| dbg_populated | output | 1 | Selected row is populated |
| dbg_first | output | 22 | First page of selected row |
| dbg_last | output | 22 | Last page of selected row |
| dbg_size | output | 22 | Page count of selected row |
| dbg_ecc | output | 2 | Correction code of selected row |

## Verification
The bench uses the default parameters: eight rows and 8-bit boundaries, which give a 22-bit page space. With these values it can place a map with populated rows separated by empty ones, and it can probe both edges of every populated row as well as the very top of the page space. It also flips the granularity bit, the channel bit and the integrity field on the same boundaries, so the page ranges and the correction codes can be seen to move independently.

// File: rtl/drbd_pkg.sv
package drbd_pkg;

  typedef enum logic [1:0] {
    ECC_OFF    = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_SYM4   = 2'd2
  } ecc_e;

  localparam int MODE_GRAN_BIT = 18;
  localparam int MODE_INT_LO   = 20;
  localparam int MODE_INT_HI   = 21;
  localparam int MODE_DUAL_BIT = 22;
  localparam int BASE_SHIFT    = 13;

  // cumulative page count for a boundary value
  function automatic logic [31:0] pages_of(input logic [15:0] bnd, input logic gran);
    logic [4:0] sh;
    sh = 5'(BASE_SHIFT) + {4'd0, gran};
    return {16'd0, bnd} << sh;
  endfunction

  // correction scheme of a row
  function automatic ecc_e ecc_of(input logic pop, input logic integ_on,
                                  input logic dual, input logic x4);
    if (!pop || !integ_on) return ECC_OFF;
    if (dual && x4)        return ECC_SYM4;
    return ECC_SECDED;
  endfunction

endpackage

// File: rtl/drbd_regs.sv
module drbd_regs #(
  parameter int NUM_ROWS = 8,
  parameter int BOUND_W  = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_ROWS-1:0][BOUND_W-1:0]  bound_q,
  output logic [4*NUM_ROWS-1:0]             attr_q,
  output logic [DATA_W-1:0]                 mode_q
);
  localparam int ATTR_ADDR = NUM_ROWS;
  localparam int MODE_ADDR = NUM_ROWS + 1;
  localparam int ATTR_W    = 4 * NUM_ROWS;

  logic wr_attr, wr_mode;
  assign wr_attr = wr_en && (int'(wr_addr) == ATTR_ADDR);
  assign wr_mode = wr_en && (int'(wr_addr) == MODE_ADDR);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_bound
    logic wr_row;
    assign wr_row = wr_en && (int'(wr_addr) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bound_q[i] <= '0;
      else if (wr_row) bound_q[i] <= wr_data[BOUND_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_attr) attr_q <= wr_data[ATTR_W-1:0];
      if (wr_mode) mode_q <= wr_data;
    end
  end

  // R1
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bound_q) && $stable(attr_q) && $stable(mode_q));

endmodule

// File: rtl/drbd_row_table.sv
module drbd_row_table
  import drbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BOUND_W  = 8,
  parameter int PAGE_W   = 22,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_ROWS-1:0][BOUND_W-1:0] bound_q,
  input  logic [4*NUM_ROWS-1:0]            attr_q,
  input  logic [DATA_W-1:0]                mode_q,
  output logic [NUM_ROWS-1:0]              row_pop,
  output logic [NUM_ROWS-1:0][PAGE_W-1:0]  row_first,
  output logic [NUM_ROWS-1:0][PAGE_W-1:0]  row_last,
  output logic [NUM_ROWS-1:0][PAGE_W-1:0]  row_size,
  output logic [NUM_ROWS-1:0]              row_x4,
  output logic [NUM_ROWS-1:0][1:0]         row_ecc
);
  logic gran, integ_on, dual;
  assign gran     = mode_q[MODE_GRAN_BIT];
  assign integ_on = |mode_q[MODE_INT_HI:MODE_INT_LO];
  assign dual     = mode_q[MODE_DUAL_BIT];

  logic [NUM_ROWS-1:0][PAGE_W-1:0] cum;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [31:0]       pg;
    logic [PAGE_W-1:0] prev;
    assign pg     = pages_of(16'(bound_q[i]), gran);
    assign cum[i] = pg[PAGE_W-1:0];
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = cum[i-1];
    end
    assign row_pop[i]   = cum[i] > prev;
    assign row_first[i] = row_pop[i] ? prev : '0;
    assign row_last[i]  = row_pop[i] ? cum[i] - 1'b1 : '0;
    assign row_size[i]  = row_pop[i] ? cum[i] - prev : '0;
    assign row_x4[i]    = attr_q[4*i+3];
    assign row_ecc[i]   = ecc_of(row_pop[i], integ_on, dual, row_x4[i]);
  end

endmodule

// File: rtl/drbd_lookup.sv
module drbd_lookup
  import drbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int PAGE_W   = 22,
  parameter int ROW_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             lkp_req,
  input  logic [PAGE_W-1:0]                lkp_page,
  input  logic [NUM_ROWS-1:0]              row_pop,
  input  logic [NUM_ROWS-1:0][PAGE_W-1:0]  row_first,
  input  logic [NUM_ROWS-1:0][PAGE_W-1:0]  row_last,
  input  logic [NUM_ROWS-1:0]              row_x4,
  input  logic [NUM_ROWS-1:0][1:0]         row_ecc,
  output logic                             lkp_valid,
  output logic                             lkp_hit,
  output logic [ROW_W-1:0]                 lkp_row,
  output logic                             lkp_x4,
  output logic [1:0]                       lkp_ecc
);
  logic [NUM_ROWS-1:0] match;
  logic                hit_d;
  logic [ROW_W-1:0]    row_d;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_match
    assign match[i] = row_pop[i] && (lkp_page >= row_first[i]) && (lkp_page <= row_last[i]);
  end

  // lowest matching row wins
  always_comb begin
    hit_d = 1'b0;
    row_d = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_d = 1'b1;
        row_d = ROW_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lkp_valid <= 1'b0;
      lkp_hit   <= 1'b0;
      lkp_row   <= '0;
      lkp_x4    <= 1'b0;
      lkp_ecc   <= ECC_OFF;
    end else begin
      lkp_valid <= lkp_req;
      if (lkp_req) begin
        lkp_hit <= hit_d;
        lkp_row <= row_d;
        lkp_x4  <= hit_d ? row_x4[row_d] : 1'b0;
        lkp_ecc <= hit_d ? row_ecc[row_d] : ECC_OFF;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> lkp_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> !lkp_valid && $stable(lkp_hit) && $stable(lkp_row));

endmodule

// File: rtl/drbd_decoder.sv
module drbd_decoder
  import drbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BOUND_W  = 8,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_ROWS + 2),
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int PAGE_W  = BOUND_W + BASE_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lkp_req,
  input  logic [PAGE_W-1:0] lkp_page,
  output logic              lkp_valid,
  output logic              lkp_hit,
  output logic [ROW_W-1:0]  lkp_row,
  output logic              lkp_x4,
  output logic [1:0]        lkp_ecc,
  input  logic [ROW_W-1:0]  dbg_row,
  output logic              dbg_populated,
  output logic [PAGE_W-1:0] dbg_first,
  output logic [PAGE_W-1:0] dbg_last,
  output logic [PAGE_W-1:0] dbg_size,
  output logic [1:0]        dbg_ecc
);
  logic [NUM_ROWS-1:0][BOUND_W-1:0] bound_q;
  logic [4*NUM_ROWS-1:0]            attr_q;
  logic [DATA_W-1:0]                mode_q;
  logic [NUM_ROWS-1:0]              row_pop;
  logic [NUM_ROWS-1:0][PAGE_W-1:0]  row_first, row_last, row_size;
  logic [NUM_ROWS-1:0]              row_x4;
  logic [NUM_ROWS-1:0][1:0]         row_ecc;

  drbd_regs #(.NUM_ROWS(NUM_ROWS), .BOUND_W(BOUND_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bound_q(bound_q), .attr_q(attr_q), .mode_q(mode_q));

  drbd_row_table #(.NUM_ROWS(NUM_ROWS), .BOUND_W(BOUND_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_table (
    .bound_q(bound_q), .attr_q(attr_q), .mode_q(mode_q),
    .row_pop(row_pop), .row_first(row_first), .row_last(row_last), .row_size(row_size),
    .row_x4(row_x4), .row_ecc(row_ecc));

  drbd_lookup #(.NUM_ROWS(NUM_ROWS), .PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_page(lkp_page),
    .row_pop(row_pop), .row_first(row_first), .row_last(row_last),
    .row_x4(row_x4), .row_ecc(row_ecc),
    .lkp_valid(lkp_valid), .lkp_hit(lkp_hit), .lkp_row(lkp_row),
    .lkp_x4(lkp_x4), .lkp_ecc(lkp_ecc));

  assign dbg_populated = row_pop[dbg_row];
  assign dbg_first     = row_first[dbg_row];
  assign dbg_last      = row_last[dbg_row];
  assign dbg_size      = row_size[dbg_row];
  assign dbg_ecc       = row_ecc[dbg_row];

  // R5
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !lkp_hit) |-> (lkp_row == '0 && !lkp_x4 && lkp_ecc == ECC_OFF));

  // R4
  hit_populated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_hit && !$past(wr_en)) |-> row_pop[lkp_row]);

  // R3
  hit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_hit && !$past(wr_en)) |->
      ($past(lkp_page) >= row_first[lkp_row] && $past(lkp_page) <= row_last[lkp_row]));

  // R8
  sym_needs_x4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ecc == ECC_SYM4) |-> lkp_x4);

endmodule

// File: tb/drbd_decoder_bench.sv
module drbd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        lkp_req = 1'b0;
  logic [21:0] lkp_page = '0;
  logic        lkp_valid, lkp_hit, lkp_x4;
  logic [2:0]  lkp_row;
  logic [1:0]  lkp_ecc;
  logic [2:0]  dbg_row = '0;
  logic        dbg_populated;
  logic [21:0] dbg_first, dbg_last, dbg_size;
  logic [1:0]  dbg_ecc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  drbd_decoder u_drbd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lkp_req(lkp_req), .lkp_page(lkp_page), .lkp_valid(lkp_valid), .lkp_hit(lkp_hit),
    .lkp_row(lkp_row), .lkp_x4(lkp_x4), .lkp_ecc(lkp_ecc), .dbg_row(dbg_row),
    .dbg_populated(dbg_populated), .dbg_first(dbg_first), .dbg_last(dbg_last),
    .dbg_size(dbg_size), .dbg_ecc(dbg_ecc));

  // map A: boundaries 2,2,5,5,5,9,9,12 in 8192-page units, rows 0 and 5 x4, dual, integrity on
  localparam int NV = 10;
  localparam int V_PAGE [NV] = '{0, 16383, 16384, 40959, 40960, 73727, 73728, 98303, 98304, 4194303};
  localparam int V_HIT  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int V_ROW  [NV] = '{0, 0, 2, 2, 5, 5, 7, 7, 0, 0};
  localparam int V_X4   [NV] = '{1, 1, 0, 0, 1, 1, 0, 0, 0, 0};
  localparam int V_ECC  [NV] = '{2, 2, 1, 1, 2, 2, 1, 1, 0, 0};
  localparam int MAP_B  [8]  = '{2, 2, 5, 5, 5, 9, 9, 12};

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input int page);
    @(negedge clk);
    lkp_req = 1'b1; lkp_page = 22'(page);
    @(negedge clk);
    lkp_req = 1'b0;
  endtask

  task automatic expect_lkp(input string req, input int hit, input int row, input int x4, input int ecc);
    check(req, "valid", int'(lkp_valid), 1);
    check(req, "hit", int'(lkp_hit), hit);
    check(req, "row", int'(lkp_row), row);
    check(req, "x4", int'(lkp_x4), x4);
    check(req, "ecc", int'(lkp_ecc), ecc);
  endtask

  task automatic load_map_a();
    for (int i = 0; i < 8; i++) write_reg(i, 32'(MAP_B[i]));
    write_reg(8, 32'h0080_0008);
    write_reg(9, 32'h0050_0000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    dbg_row = 3'd0;
    @(negedge clk);
    check("R11", "dbg_populated", int'(dbg_populated), 0);
    check("R11", "dbg_size", int'(dbg_size), 0);
    check("R11", "valid at rest", int'(lkp_valid), 0);
    lookup(0);
    expect_lkp("R11", 0, 0, 0, 0);

    load_map_a();

    // R2 R3 R4 R5 R6 R8: vector table
    for (int v = 0; v < NV; v++) begin
      lookup(V_PAGE[v]);
      expect_lkp(V_HIT[v] != 0 ? "R3" : "R5", V_HIT[v], V_ROW[v], V_X4[v], V_ECC[v]);
    end

    // R9: valid is a one-cycle pulse, result holds
    lookup(16384);
    @(negedge clk);
    check("R9", "valid drops", int'(lkp_valid), 0);
    check("R9", "row held", int'(lkp_row), 2);

    // R10: debug view of a populated and an empty row
    dbg_row = 3'd2;
    #1;
    check("R10", "first", int'(dbg_first), 16384);
    check("R10", "last", int'(dbg_last), 40959);
    check("R10", "size", int'(dbg_size), 24576);
    check("R10", "ecc", int'(dbg_ecc), 1);
    dbg_row = 3'd1;
    #1;
    check("R4", "empty populated", int'(dbg_populated), 0);
    check("R10", "empty size", int'(dbg_size), 0);
    check("R10", "empty first", int'(dbg_first), 0);
    check("R10", "empty ecc", int'(dbg_ecc), 0);

    // R1: writes to unused addresses are ignored
    write_reg(10, 32'hFFFF_FFFF);
    write_reg(15, 32'hFFFF_FFFF);
    lookup(16384);
    expect_lkp("R1", 1, 2, 0, 1);
    lookup(98304);
    expect_lkp("R1", 0, 0, 0, 0);

    // R2: 64 MiB granularity doubles every range
    write_reg(9, 32'h0054_0000);
    lookup(20000);
    expect_lkp("R2", 1, 0, 1, 2);
    lookup(40000);
    expect_lkp("R2", 1, 2, 0, 1);
    lookup(196607);
    expect_lkp("R2", 1, 7, 0, 1);
    lookup(196608);
    expect_lkp("R5", 0, 0, 0, 0);

    // R8: single channel gives SECDED on an x4 row
    write_reg(9, 32'h0010_0000);
    lookup(0);
    expect_lkp("R8", 1, 0, 1, 1);

    // R7: integrity off gives no correction on every row
    write_reg(9, 32'h0040_0000);
    lookup(0);
    expect_lkp("R7", 1, 0, 1, 0);
    lookup(73727);
    expect_lkp("R7", 1, 5, 1, 0);

    // R6: attribute change moves x4 to row 2
    write_reg(9, 32'h0050_0000);
    write_reg(8, 32'h0000_0800);
    lookup(16384);
    expect_lkp("R6", 1, 2, 1, 2);
    lookup(0);
    expect_lkp("R6", 1, 0, 0, 1);

    // R4: boundary equal to predecessor empties row 7
    write_reg(7, 32'd9);
    lookup(73728);
    expect_lkp("R4", 0, 0, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule